// File: doc/BRIEF.md
# Signed Widening Multiply-Accumulate Vector Unit

This unit is an integer vector datapath. It takes two 128-bit source vectors and one 128-bit accumulator vector. From one 64-bit half of each source it takes signed narrow elements. It multiplies each pair, widens the product to twice the element width, and adds that product to the matching wide accumulator lane or subtracts it. The element width is chosen on each operation by a 2-bit size code. A half-select input chooses the low or high 64 bits of both sources. The same lane hardware serves both accumulate and subtract.

An operation is launched with a one-cycle valid strobe, and the 128-bit result is registered one cycle later with its own valid strobe. Arithmetic wraps within each lane and produces no flags. The reserved size code is rejected with a one-cycle illegal-size pulse, and the result register is left as it was.

Top module: `widen_mac_unit`

## Requirements
- R1: After reset, `out_valid` and `size_illegal` are 0 and `result` is all zeros.
- R2: The size code selects the source element width N and the number of lanes: 2'b00 gives N=8 with 8 lanes, 2'b01 gives N=16 with 4 lanes, and 2'b10 gives N=32 with 2 lanes. Lane i of `result` and `acc_in` is bits (i+1)*2N-1:i*2N. Lane i of the selected source half is bits (i+1)*N-1:i*N of that half.
- R3: When `upper_half` is 0, source elements are taken from bits 63:0 of `src_a` and `src_b`. When it is 1, they are taken from bits 127:64.
- R4: Both source elements are signed two's-complement values. The most negative value times itself gives +2^(2N-2).
- R5: When `sub_mode` is 0, each lane result is the accumulator lane plus the product. When `sub_mode` is 1, it is the accumulator lane minus the product.
- R6: Each lane sum or difference wraps modulo 2^(2N), with no saturation and no carry into the neighbouring lane.
- R7: `result` and `out_valid` update exactly one cycle after a strobe of `in_valid` with a legal size. Back-to-back strobes give results in order, one per cycle.
- R8: A strobe of `in_valid` with size code 2'b11 raises `size_illegal` for exactly the next cycle. In that cycle `out_valid` stays 0 and `result` keeps its previous value.
- R9: While `in_valid` is 0, `out_valid` is 0 and `result` holds its value, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Launches one operation this cycle |
| size_code | input | 2 | Source element width: 00=8, 01=16, 10=32, 11 reserved |
| upper_half | input | 1 | 0 selects source bits 63:0, 1 selects bits 127:64 |
| sub_mode | input | 1 | 0 accumulates the product, 1 subtracts it |
| src_a | input | 128 | First signed source vector |
| src_b | input | 128 | Second signed source vector |
| acc_in | input | 128 | Wide accumulator vector |
| out_valid | output | 1 | Result register was loaded in the previous cycle |
| result | output | 128 | Registered wide lane results |
| size_illegal | output | 1 | One-cycle pulse after a reserved size code |

## Verification
Random operands for every size, half and mode are compared lane by lane with a model that sign-extends to 64 bits. Such operands catch wrong lane slicing or a missing sign extension, but they rarely reach the extremes. For the extremes, lanes filled with the most negative value separate a signed multiply from an unsigned one. Accumulators of all ones or of the most positive value, plus a product of one, show that each lane wraps within its own width and does not carry into its neighbour. Sources that differ between their two halves separate the half-select settings. A reserved size code given between legal operations shows that the result register is not touched.

// File: rtl/widen_mac_pkg.sv
package widen_mac_pkg;

  // size codes; their numeric value is the shift applied to the base width
  typedef enum logic [1:0] {
    ESZ_BYTE = 2'b00,
    ESZ_HALF = 2'b01,
    ESZ_WORD = 2'b10,
    ESZ_RSVD = 2'b11
  } elem_size_e;

  localparam int DEF_VEC_W    = 128;
  localparam int DEF_BASE_EW  = 8;
  localparam int DEF_NUM_SIZE = 3;
  localparam int SIZE_CODE_W  = 2;

endpackage

// File: rtl/widen_mac_half.sv
// Picks the low or high half of a source vector.
module widen_mac_half #(
  parameter int VEC_W = 128
) (
  input  logic [VEC_W-1:0]   src,
  input  logic               upper,
  output logic [VEC_W/2-1:0] half_out
);
  localparam int HALF_W = VEC_W / 2;

  assign half_out = upper ? src[VEC_W-1:HALF_W] : src[HALF_W-1:0];
endmodule

// File: rtl/widen_mac_lanes.sv
// All lanes for one element width: sign-extend, multiply, accumulate or subtract.
module widen_mac_lanes #(
  parameter int EW     = 8,
  parameter int HALF_W = 64
) (
  input  logic [HALF_W-1:0]   half_a,
  input  logic [HALF_W-1:0]   half_b,
  input  logic [2*HALF_W-1:0] acc,
  input  logic                sub,
  output logic [2*HALF_W-1:0] res
);
  localparam int WW    = 2 * EW;
  localparam int LANES = HALF_W / EW;

  // Product and sum kept to WW bits, so the lane wraps modulo 2^WW
  function automatic logic [WW-1:0] lane_mac(
    input logic [EW-1:0] a,
    input logic [EW-1:0] b,
    input logic [WW-1:0] acc_lane,
    input logic          do_sub
  );
    logic [WW-1:0] ext_a;
    logic [WW-1:0] ext_b;
    logic [WW-1:0] prod;
    ext_a = {{EW{a[EW-1]}}, a};
    ext_b = {{EW{b[EW-1]}}, b};
    prod  = ext_a * ext_b;
    return do_sub ? (acc_lane - prod) : (acc_lane + prod);
  endfunction

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign res[i*WW +: WW] = lane_mac(half_a[i*EW +: EW], half_b[i*EW +: EW],
                                      acc[i*WW +: WW], sub);
  end
endmodule

// File: rtl/widen_mac_unit.sv
// Top: widening signed multiply-accumulate over a run-time element size.
module widen_mac_unit
  import widen_mac_pkg::*;
#(
  parameter int VEC_W    = DEF_VEC_W,
  parameter int BASE_EW  = DEF_BASE_EW,
  parameter int NUM_SIZE = DEF_NUM_SIZE
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [SIZE_CODE_W-1:0] size_code,
  input  logic                   upper_half,
  input  logic                   sub_mode,
  input  logic [VEC_W-1:0]       src_a,
  input  logic [VEC_W-1:0]       src_b,
  input  logic [VEC_W-1:0]       acc_in,
  output logic                   out_valid,
  output logic [VEC_W-1:0]       result,
  output logic                   size_illegal
);
  localparam int HALF_W = VEC_W / 2;

  logic [HALF_W-1:0] half_a;
  logic [HALF_W-1:0] half_b;
  logic [VEC_W-1:0]  lane_res [NUM_SIZE];
  logic [VEC_W-1:0]  sel_res;

  // named events, also seen by the checker
  logic size_ok;
  logic op_accept;
  logic op_reject;

  widen_mac_half #(.VEC_W(VEC_W)) u_half_a (
    .src(src_a), .upper(upper_half), .half_out(half_a)
  );
  widen_mac_half #(.VEC_W(VEC_W)) u_half_b (
    .src(src_b), .upper(upper_half), .half_out(half_b)
  );

  for (genvar k = 0; k < NUM_SIZE; k++) begin : g_size
    widen_mac_lanes #(.EW(BASE_EW << k), .HALF_W(HALF_W)) u_lanes (
      .half_a (half_a),
      .half_b (half_b),
      .acc    (acc_in),
      .sub    (sub_mode),
      .res    (lane_res[k])
    );
  end

  always_comb begin
    sel_res = '0;
    for (int k = 0; k < NUM_SIZE; k++) begin
      if (int'(size_code) == k) sel_res = lane_res[k];
    end
  end

  assign size_ok   = int'(size_code) < NUM_SIZE;
  assign op_accept = in_valid & size_ok;
  assign op_reject = in_valid & ~size_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result       <= '0;
      out_valid    <= 1'b0;
      size_illegal <= 1'b0;
    end else begin
      out_valid    <= op_accept;
      size_illegal <= op_reject;
      if (op_accept) result <= sel_res;
    end
  end
endmodule

// File: rtl/widen_mac_chk.sv
// Temporal checks on the unit, attached by bind.
module widen_mac_chk #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_accept,
  input logic             op_reject,
  input logic             out_valid,
  input logic             size_illegal,
  input logic [VEC_W-1:0] result
);
  // R7
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_accept |=> out_valid);

  // R8
  illegal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_reject |=> (size_illegal && !out_valid));

  // R8
  illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    size_illegal |-> $stable(result));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(result));

  // R9
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_accept |=> !out_valid);

  // R8
  exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_valid, size_illegal}));
endmodule

bind widen_mac_unit widen_mac_chk #(.VEC_W(VEC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .op_accept    (op_accept),
  .op_reject    (op_reject),
  .out_valid    (out_valid),
  .size_illegal (size_illegal),
  .result       (result)
);

// File: tb/sim_widen_mac_unit.sv
`timescale 1ns/1ps
module sim_widen_mac_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [1:0]   size_code = 2'b00;
  logic         upper_half = 1'b0;
  logic         sub_mode = 1'b0;
  logic [127:0] src_a = '0;
  logic [127:0] src_b = '0;
  logic [127:0] acc_in = '0;
  logic         out_valid;
  logic [127:0] result;
  logic         size_illegal;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  widen_mac_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size_code(size_code),
    .upper_half(upper_half), .sub_mode(sub_mode), .src_a(src_a), .src_b(src_b),
    .acc_in(acc_in), .out_valid(out_valid), .result(result), .size_illegal(size_illegal)
  );

  // Independent model: everything done at 64 bits, then trimmed to the lane width
  function automatic logic [127:0] model(input logic [1:0] sz, input logic hi, input logic sb,
                                         input logic [127:0] a, input logic [127:0] b,
                                         input logic [127:0] acc);
    int n = 8 << sz;
    int lanes = 64 / n;
    logic [63:0] ha = hi ? a[127:64] : a[63:0];
    logic [63:0] hb = hi ? b[127:64] : b[63:0];
    logic [63:0] m1 = (64'd1 << n) - 64'd1;
    logic [63:0] m2 = (n == 32) ? {64{1'b1}} : ((64'd1 << (2*n)) - 64'd1);
    logic [127:0] out = '0;
    for (int l = 0; l < lanes; l++) begin
      logic [63:0] ea, eb, ex, s;
      logic [127:0] t;
      ea = (ha >> (l*n)) & m1;
      eb = (hb >> (l*n)) & m1;
      if (ea[n-1]) ea = ea | ~m1;
      if (eb[n-1]) eb = eb | ~m1;
      t  = acc >> (l*2*n);
      ex = t[63:0] & m2;
      s  = sb ? (ex - ea*eb) : (ex + ea*eb);
      out = out | ({64'd0, s & m2} << (l*2*n));
    end
    return out;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one strobe; returns with outputs of that operation visible
  task automatic issue(input logic [1:0] sz, input logic hi, input logic sb,
                       input logic [127:0] a, input logic [127:0] b, input logic [127:0] acc);
    @(negedge clk);
    size_code = sz; upper_half = hi; sub_mode = sb;
    src_a = a; src_b = b; acc_in = acc; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // replicate an N-bit pattern across the 128-bit vector
  function automatic logic [127:0] fill(input int n, input logic [63:0] v);
    logic [127:0] o = '0;
    for (int i = 0; i < 128 / n; i++) o = o | ({64'd0, v} << (i*n));
    return o;
  endfunction

  task automatic t_reset();
    chk(out_valid == 1'b0 && size_illegal == 1'b0, "R1 reset flags",
        {126'd0, out_valid, size_illegal}, '0);
    chk(result == '0, "R1 reset result", result, '0);
  endtask

  task automatic t_random();
    for (int sz = 0; sz < 3; sz++)
      for (int hi = 0; hi < 2; hi++)
        for (int sb = 0; sb < 2; sb++)
          for (int r = 0; r < 4; r++) begin
            logic [127:0] a = rnd128(), b = rnd128(), c = rnd128(), e;
            e = model(2'(sz), 1'(hi), 1'(sb), a, b, c);
            issue(2'(sz), 1'(hi), 1'(sb), a, b, c);
            chk(out_valid && result == e, sb ? "R5 R2 random subtract" : "R2 R5 random add",
                result, e);
          end
  endtask

  task automatic t_halves();
    // low half holds +1 lanes, high half holds +3 lanes: results differ by half
    logic [127:0] a = {64'h0303030303030303, 64'h0101010101010101};
    logic [127:0] e;
    issue(2'b00, 1'b0, 1'b0, a, a, '0);
    e = fill(16, 64'd1);
    chk(result == e, "R3 lower half", result, e);
    issue(2'b00, 1'b1, 1'b0, a, a, '0);
    e = fill(16, 64'd9);
    chk(result == e, "R3 upper half", result, e);
  endtask

  task automatic t_most_neg();
    for (int sz = 0; sz < 3; sz++)
      for (int hi = 0; hi < 2; hi++) begin
        int n = 8 << sz;
        logic [127:0] a = fill(n, 64'd1 << (n-1));
        logic [127:0] e = fill(2*n, 64'd1 << (2*n-2));
        issue(2'(sz), 1'(hi), 1'b0, a, a, '0);
        chk(result == e, "R4 most negative squared", result, e);
        chk(result == model(2'(sz), 1'(hi), 1'b0, a, a, '0), "R4 model agrees",
            result, model(2'(sz), 1'(hi), 1'b0, a, a, '0));
      end
  endtask

  task automatic t_wrap();
    for (int sz = 0; sz < 3; sz++)
      for (int hi = 0; hi < 2; hi++) begin
        int n = 8 << sz;
        logic [127:0] one = fill(n, 64'd1);
        logic [127:0] mx = fill(2*n, (64'd1 << (2*n-1)) - 64'd1);
        logic [127:0] e;
        // all-ones accumulator plus 1 -> zero, no carry into next lane
        issue(2'(sz), 1'(hi), 1'b0, one, one, {128{1'b1}});
        chk(result == '0, "R6 wrap all ones", result, '0);
        // most positive plus 1 -> most negative
        e = fill(2*n, 64'd1 << (2*n-1));
        issue(2'(sz), 1'(hi), 1'b0, one, one, mx);
        chk(result == e, "R6 wrap most positive", result, e);
        // zero minus 1 -> all ones
        issue(2'(sz), 1'(hi), 1'b1, one, one, '0);
        chk(result == {128{1'b1}}, "R5 R6 subtract borrow", result, {128{1'b1}});
      end
  endtask

  task automatic t_latency();
    logic [127:0] a1 = rnd128(), a2 = rnd128(), e1, e2;
    e1 = model(2'b01, 1'b0, 1'b0, a1, a2, a1);
    e2 = model(2'b10, 1'b1, 1'b1, a2, a1, a2);
    @(negedge clk);
    size_code = 2'b01; upper_half = 1'b0; sub_mode = 1'b0;
    src_a = a1; src_b = a2; acc_in = a1; in_valid = 1'b1;
    chk(out_valid == 1'b0, "R7 not early", {127'd0, out_valid}, '0);
    @(negedge clk);
    chk(out_valid && result == e1, "R7 first of pair", result, e1);
    size_code = 2'b10; upper_half = 1'b1; sub_mode = 1'b1;
    src_a = a2; src_b = a1; acc_in = a2;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && result == e2, "R7 second of pair", result, e2);
    @(negedge clk);
    chk(out_valid == 1'b0, "R7 valid drops", {127'd0, out_valid}, '0);
  endtask

  task automatic t_illegal();
    logic [127:0] prev;
    issue(2'b00, 1'b0, 1'b0, rnd128(), rnd128(), rnd128());
    prev = result;
    issue(2'b11, 1'b0, 1'b0, rnd128(), rnd128(), rnd128());
    chk(size_illegal == 1'b1 && out_valid == 1'b0, "R8 flag raised",
        {126'd0, size_illegal, out_valid}, 128'd2);
    chk(result == prev, "R8 result kept", result, prev);
    @(negedge clk);
    chk(size_illegal == 1'b0, "R8 flag one cycle", {127'd0, size_illegal}, '0);
  endtask

  task automatic t_idle();
    logic [127:0] prev = result;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      size_code = 2'(i); src_a = rnd128(); src_b = rnd128(); acc_in = rnd128();
      sub_mode = ~sub_mode;
    end
    @(negedge clk);
    chk(result == prev && out_valid == 1'b0, "R9 idle hold", result, prev);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    #3;
    t_reset();
    #10 rst_n = 1'b1;
    t_random();
    t_halves();
    t_most_neg();
    t_wrap();
    t_latency();
    t_illegal();
    t_idle();
    finish_run();
  end
endmodule